// File: doc/BRIEF.md
# Four-Way Translation Cache with Address-Space Tags

This block holds recently used virtual-to-physical page mappings for a 32-bit virtual address space with 4 KB pages. A lookup presents a virtual address, the current address-space identifier and the kind of access (read or write, user or supervisor). One cycle later the block answers with hit, miss or protection fault. On a hit it also returns the translated physical address and the stored page flags. A miss is only reported; an external page walker fetches the mapping and writes it in through the fill port.

Each entry stores an address-space identifier, so mappings from several processes can live side by side. An entry marked global matches under any identifier. The flush command clears every entry except the global ones, so shared kernel and library pages stay cached across context switches. The storage is 16 sets of 4 ways. The victim way is picked from a 3-bit tree pseudo-LRU state held per set.

Top module: `tlb_asid`

## Requirements
- R1: A lookup issued in cycle N is answered in cycle N+1 (`rsp_valid` high). On a hit the physical address is the entry's 20-bit page number above bits [11:0] of the virtual address, which pass through unchanged.
- R2: Bits [15:12] of the virtual address (the low 4 bits of the page number) pick one of 16 sets, and bits [31:16] form the tag. Fills to one set never disturb another set.
- R3: A hit needs a valid entry in the selected set whose tag equals the request tag and whose identifier equals the request identifier. Any other request misses.
- R4: An entry whose global flag (flag bit 2) is set hits for a matching tag whatever the request identifier.
- R5: A flush clears all entries whose global flag is clear and keeps the global ones. A lookup in the flush cycle still sees the contents from before the flush. A fill in the flush cycle is kept.
- R6: A write (`lk_write`=1) that matches an entry whose writeable flag (bit 3) is clear gives `rsp_fault`=1, `rsp_hit`=0 and a physical address of zero.
- R7: A user-mode access (`lk_user`=1) that matches an entry whose user flag (bit 1) is clear gives `rsp_fault`=1, `rsp_hit`=0 and a physical address of zero. Supervisor accesses ignore the user flag.
- R8: If a fill and a lookup go to the same set in the same cycle, the fill is written and the lookup reports a miss.
- R9: A fill first replaces any valid entry in its set with the same tag that the new mapping would also match. Such an entry has the same identifier, or either entry is global. No set ever holds two entries matching one lookup.
- R10: With no matching entry, a fill takes the lowest-numbered invalid way. If all ways are valid, it takes the way named by the pseudo-LRU tree. Root bit b0=0 means ways 0/1 and b0=1 means ways 2/3; b1 picks way 0 (0) or way 1 (1), and b2 picks way 2 (0) or way 3 (1). A fill or a lookup hit to way w turns the bits on its path away from w. Reset clears the tree bits.
- R11: A miss or fault returns a physical address of zero and flags of zero. With no lookup in a cycle, `rsp_valid`, `rsp_hit` and `rsp_fault` are low in the next cycle. After reset all entries are invalid and all outputs are low.
- R12: On a hit, `rsp_flags` returns the 7 flags stored by the fill: bit0 present, bit1 user-accessible, bit2 global, bit3 writeable, bit4 dirty, bit5 used-recently, bit6 cacheable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| fill_valid | input | 1 | Insert a mapping |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_asid | input | 8 | Identifier of the mapping |
| fill_ppn | input | 20 | Physical page number of the mapping |
| fill_flags | input | 7 | Page flags of the mapping |
| flush | input | 1 | Invalidate all non-global entries |
| rsp_valid | output | 1 | Response to last cycle's lookup |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Translation found but access denied |
| rsp_paddr | output | 32 | Physical address on hit, else zero |
| rsp_flags | output | 7 | Stored flags on hit, else zero |

## Verification
The hardest state to reach is a full set in which pseudo-LRU order, duplicate replacement and same-cycle fill, lookup and flush all interact. Which way gets evicted depends on the whole history of hits and fills in that set. The random phase therefore limits addresses to two sets, six tags and three identifiers, so sets fill up, overflow and collide with same-cycle lookups many times. A reference model in the bench follows the documented tree policy. Directed sequences add a worked eviction in which one touched way changes the victim, and a flush issued together with a fill and a lookup.

// File: rtl/tlb_asid.sv
`timescale 1ns/1ps
module tlb_asid #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int SET_W  = 4,
  parameter int ASID_W = 8,
  parameter int PPN_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic [ASID_W-1:0]       lk_asid,
  input  logic                    lk_write,
  input  logic                    lk_user,
  input  logic                    fill_valid,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic [PPN_W-1:0]        fill_ppn,
  input  logic [6:0]              fill_flags,
  input  logic                    flush,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_fault,
  output logic [PPN_W+OFF_W-1:0]  rsp_paddr,
  output logic [6:0]              rsp_flags
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 4;
  localparam int N     = SETS * WAYS;
  localparam int F_USR = 1;
  localparam int F_GLB = 2;
  localparam int F_WR  = 3;

  logic [N-1:0]        v_q;
  logic [TAG_W-1:0]    tag_q  [N];
  logic [ASID_W-1:0]   asid_q [N];
  logic [PPN_W-1:0]    ppn_q  [N];
  logic [6:0]          fl_q   [N];
  logic [2:0]          plru_q [SETS];

  function automatic logic [2:0] touch(input logic [2:0] p, input logic [1:0] w);
    case (w)
      2'd0:    return {p[2], 2'b11};
      2'd1:    return {p[2], 2'b01};
      2'd2:    return {1'b1, p[1], 1'b0};
      default: return {1'b0, p[1], 1'b0};
    endcase
  endfunction

  function automatic logic [1:0] victim(input logic [2:0] p);
    return p[0] ? {1'b1, p[2]} : {1'b0, p[1]};
  endfunction

  wire [SET_W-1:0] l_set = lk_vaddr[OFF_W +: SET_W];
  wire [TAG_W-1:0] l_tag = lk_vaddr[VA_W-1 -: TAG_W];
  wire [SET_W-1:0] f_set = fill_vpn[SET_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_vpn[VPN_W-1 -: TAG_W];

  logic             l_any;
  logic [1:0]       l_way;
  logic [PPN_W-1:0] l_ppn;
  logic [6:0]       l_fl;

  always_comb begin
    logic [SET_W+1:0] ix;
    l_any = 1'b0; l_way = '0; l_ppn = '0; l_fl = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      ix = {l_set, 2'(w)};
      if (v_q[ix] && tag_q[ix] == l_tag && (fl_q[ix][F_GLB] || asid_q[ix] == lk_asid)) begin
        l_any = 1'b1; l_way = 2'(w); l_ppn = ppn_q[ix]; l_fl = fl_q[ix];
      end
    end
  end

  logic [WAYS-1:0] f_dup;
  logic            f_hasdup, f_hasinv;
  logic [1:0]      f_dupw, f_invw, f_way;

  always_comb begin
    logic [SET_W+1:0] ix;
    f_dup = '0; f_hasdup = 1'b0; f_hasinv = 1'b0; f_dupw = '0; f_invw = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      ix = {f_set, 2'(w)};
      f_dup[w] = v_q[ix] && tag_q[ix] == f_tag &&
                 (fl_q[ix][F_GLB] || fill_flags[F_GLB] || asid_q[ix] == fill_asid);
      if (f_dup[w]) begin f_hasdup = 1'b1; f_dupw = 2'(w); end
      if (!v_q[ix]) begin f_hasinv = 1'b1; f_invw = 2'(w); end
    end
    f_way = f_hasdup ? f_dupw : (f_hasinv ? f_invw : victim(plru_q[f_set]));
  end

  wire clash = lk_valid && fill_valid && (l_set == f_set);
  wire l_ok  = lk_valid && l_any && !clash;
  wire viol  = (lk_write && !l_fl[F_WR]) || (lk_user && !l_fl[F_USR]);
  wire good  = l_ok && !viol;
  wire [SET_W+1:0] f_ix = {f_set, f_way};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_flags <= '0;
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= good;
      rsp_fault <= l_ok && viol;
      rsp_paddr <= good ? {l_ppn, lk_vaddr[OFF_W-1:0]} : '0;
      rsp_flags <= good ? l_fl : '0;
      if (good) plru_q[l_set] <= touch(plru_q[l_set], l_way);
      if (flush)
        for (int i = 0; i < N; i++)
          if (!fl_q[i][F_GLB]) v_q[i] <= 1'b0;
      if (fill_valid) begin
        for (int w = 0; w < WAYS; w++)
          if (f_dup[w] && 2'(w) != f_way) v_q[{f_set, 2'(w)}] <= 1'b0;
        v_q[f_ix]     <= 1'b1;
        tag_q[f_ix]   <= f_tag;
        asid_q[f_ix]  <= fill_asid;
        ppn_q[f_ix]   <= fill_ppn;
        fl_q[f_ix]    <= fill_flags;
        plru_q[f_set] <= touch(plru_q[f_set], f_way);
      end
    end
  end
endmodule

// File: rtl/tlb_asid_chk.sv
`timescale 1ns/1ps
module tlb_asid_chk #(
  parameter int OFF_W = 12,
  parameter int SET_W = 4,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [OFF_W-1:0] lk_off,
  input logic [SET_W-1:0] lk_set,
  input logic             lk_write,
  input logic             lk_user,
  input logic             fill_valid,
  input logic [SET_W-1:0] fill_set,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_off));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);

  assert_hit_fault_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));

  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> ($past(lk_write) || $past(lk_user)));

  assert_clash_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fill_valid && lk_set == fill_set) |=> (!rsp_hit && !rsp_fault));
endmodule

bind tlb_asid tlb_asid_chk #(.OFF_W(OFF_W), .SET_W(SET_W), .PA_W(PPN_W+OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
  .lk_off(lk_vaddr[OFF_W-1:0]), .lk_set(lk_vaddr[OFF_W +: SET_W]),
  .lk_write(lk_write), .lk_user(lk_user),
  .fill_valid(fill_valid), .fill_set(fill_vpn[SET_W-1:0]),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/tb_tlb_asid.sv
`timescale 1ns/1ps
module tb_tlb_asid;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, lk_valid, lk_write, lk_user, fill_valid, flush;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid, fill_asid;
  logic [19:0] fill_vpn, fill_ppn;
  logic [6:0]  fill_flags;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [6:0]  rsp_flags;

  tlb_asid dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_write(lk_write), .lk_user(lk_user), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_ppn(fill_ppn), .fill_flags(fill_flags), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  bit          mv    [64];
  logic [15:0] mtag  [64];
  logic [7:0]  masid [64];
  logic [19:0] mppn  [64];
  logic [6:0]  mfl   [64];
  logic [2:0]  mplru [16];

  function automatic logic [2:0] tree_touch(logic [2:0] p, int w);
    logic [2:0] r = p;
    if (w < 2) begin r[0] = 1'b1; r[1] = (w == 0); end
    else       begin r[0] = 1'b0; r[2] = (w == 2); end
    return r;
  endfunction

  function automatic int tree_victim(logic [2:0] p);
    if (p[0]) return p[2] ? 3 : 2;
    return p[1] ? 1 : 0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit lv, logic [31:0] va, logic [7:0] la, bit lw, bit lu,
                      bit fv, logic [19:0] fvpn, logic [7:0] fa, logic [19:0] fp,
                      logic [6:0] ff, bit fl);
    int ls, fs, way, fw;
    bit found, clash, viol, eh, ef, hasinv;
    bit dup [4];
    logic [31:0] ep;
    logic [6:0]  eflg;
    lk_valid = lv; lk_vaddr = va; lk_asid = la; lk_write = lw; lk_user = lu;
    fill_valid = fv; fill_vpn = fvpn; fill_asid = fa; fill_ppn = fp; fill_flags = ff; flush = fl;
    ls = int'(va[15:12]); fs = int'(fvpn[3:0]);
    clash = lv && fv && (ls == fs);
    found = 0; way = 0;
    for (int w = 0; w < 4; w++) begin
      int i = ls*4 + w;
      if (!found && mv[i] && mtag[i] == va[31:16] && (mfl[i][2] || masid[i] == la)) begin
        found = 1; way = w;
      end
    end
    viol = found && ((lw && !mfl[ls*4+way][3]) || (lu && !mfl[ls*4+way][1]));
    eh = lv && found && !clash && !viol;
    ef = lv && found && !clash && viol;
    ep = eh ? {mppn[ls*4+way], va[11:0]} : 32'h0;
    eflg = eh ? mfl[ls*4+way] : 7'h0;
    fw = -1; hasinv = 0;
    for (int w = 0; w < 4; w++) begin
      int i = fs*4 + w;
      dup[w] = mv[i] && mtag[i] == fvpn[19:4] && (mfl[i][2] || ff[2] || masid[i] == fa);
      if (dup[w] && fw < 0) fw = w;
    end
    if (fw < 0) for (int w = 3; w >= 0; w--) if (!mv[fs*4+w]) begin fw = w; hasinv = 1; end
    if (fw < 0) fw = tree_victim(mplru[fs]);
    if (eh) mplru[ls] = tree_touch(mplru[ls], way);
    if (fl) for (int i = 0; i < 64; i++) if (!mfl[i][2]) mv[i] = 0;
    if (fv) begin
      for (int w = 0; w < 4; w++) if (dup[w] && w != fw) mv[fs*4+w] = 0;
      mv[fs*4+fw] = 1; mtag[fs*4+fw] = fvpn[19:4]; masid[fs*4+fw] = fa;
      mppn[fs*4+fw] = fp; mfl[fs*4+fw] = ff; mplru[fs] = tree_touch(mplru[fs], fw);
    end
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; flush = 0;
    chk(req, "valid", {31'b0, rsp_valid}, {31'b0, lv});
    if (lv) begin
      chk(req, "hit",   {31'b0, rsp_hit},   {31'b0, eh});
      chk(req, "fault", {31'b0, rsp_fault}, {31'b0, ef});
      chk(req, "paddr", rsp_paddr, ep);
      chk(req, "flags", {25'b0, rsp_flags}, {25'b0, eflg});
    end
  endtask

  task automatic look(string req, logic [31:0] va, logic [7:0] a, bit w, bit u);
    step(req, 1, va, a, w, u, 0, 20'h0, 8'h0, 20'h0, 7'h0, 0);
  endtask

  task automatic put(string req, logic [19:0] vpn, logic [7:0] a, logic [19:0] p, logic [6:0] f);
    step(req, 0, 32'h0, 8'h0, 0, 0, 1, vpn, a, p, f, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mv[i] = 0; mfl[i] = 0; end
    for (int s = 0; s < 16; s++) mplru[s] = 0;
    rst_n = 0; lk_valid = 0; lk_vaddr = 0; lk_asid = 0; lk_write = 0; lk_user = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_ppn = 0; fill_flags = 0; flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R11", "reset valid", {31'b0, rsp_valid}, 32'h0);
    chk("R11", "reset hit",   {31'b0, rsp_hit},   32'h0);
    chk("R11", "reset paddr", rsp_paddr, 32'h0);
    look("R11", 32'h12345678, 8'd5, 0, 0);

    put("R1", 20'h12345, 8'd5, 20'hABCDE, 7'b0101011);
    look("R1", 32'h12345678, 8'd5, 0, 1);
    chk("R1", "paddr literal", rsp_paddr, 32'hABCDE678);
    chk("R12", "flags literal", {25'b0, rsp_flags}, 32'h2B);
    look("R3", 32'h12345678, 8'd6, 0, 0);
    chk("R3", "asid mismatch hit", {31'b0, rsp_hit}, 32'h0);
    look("R3", 32'h22345678, 8'd5, 0, 0);

    put("R4", 20'h00071, 8'd1, 20'h00777, 7'b1001111);
    look("R4", 32'h00071ABC, 8'd9, 1, 1);
    chk("R4", "global hit", {31'b0, rsp_hit}, 32'h1);

    put("R6", 20'h00082, 8'd5, 20'h00888, 7'b0000011);
    look("R6", 32'h00082010, 8'd5, 1, 0);
    chk("R6", "write fault", {31'b0, rsp_fault}, 32'h1);
    look("R6", 32'h00082010, 8'd5, 0, 1);

    put("R7", 20'h00093, 8'd5, 20'h00999, 7'b0001001);
    look("R7", 32'h00093020, 8'd5, 0, 1);
    chk("R7", "user fault", {31'b0, rsp_fault}, 32'h1);
    look("R7", 32'h00093020, 8'd5, 1, 0);

    step("R8", 1, 32'h12345678, 8'd5, 0, 0, 1, 20'h00015, 8'd3, 20'h01515, 7'b0001011, 0);
    chk("R8", "clash hit", {31'b0, rsp_hit}, 32'h0);
    look("R8", 32'h12345678, 8'd5, 0, 0);
    look("R8", 32'h00015000, 8'd3, 0, 0);

    put("R9", 20'h12345, 8'd5, 20'h11111, 7'b0001011);
    look("R9", 32'h12345678, 8'd5, 0, 0);
    chk("R9", "replaced paddr", rsp_paddr, 32'h11111678);

    for (int t = 1; t <= 4; t++) put("R10", {16'(t), 4'hA}, 8'd2, 20'(t*16), 7'b0001011);
    look("R10", 32'h0001A000, 8'd2, 0, 0);
    put("R10", 20'h0005A, 8'd2, 20'h00050, 7'b0001011);
    look("R10", 32'h0003A000, 8'd2, 0, 0);
    chk("R10", "victim way2 gone", {31'b0, rsp_hit}, 32'h0);
    for (int t = 1; t <= 5; t++) if (t != 3) look("R10", {16'(t), 4'hA, 12'h0}, 8'd2, 0, 0);
    look("R2", 32'h00071000, 8'd1, 0, 0);
    chk("R2", "other set intact", {31'b0, rsp_hit}, 32'h1);

    step("R5", 1, 32'h00082000, 8'd5, 0, 0, 0, 20'h0, 8'h0, 20'h0, 7'h0, 1);
    chk("R5", "pre-flush hit", {31'b0, rsp_hit}, 32'h1);
    look("R5", 32'h00082000, 8'd5, 0, 0);
    chk("R5", "flushed", {31'b0, rsp_hit}, 32'h0);
    look("R5", 32'h00071000, 8'd4, 0, 0);
    chk("R5", "global kept", {31'b0, rsp_hit}, 32'h1);
    step("R5", 0, 32'h0, 8'h0, 0, 0, 1, 20'h00333, 8'd4, 20'h03333, 7'b0001011, 1);
    look("R5", 32'h00333000, 8'd4, 0, 0);
    chk("R5", "fill beside flush", {31'b0, rsp_hit}, 32'h1);

    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      bit lv, fv, fl;
      logic [6:0] f;
      string tag;
      lv = ($urandom % 10) < 7;
      fv = ($urandom % 10) < 4;
      fl = ($urandom % 64) == 0;
      f = 7'($urandom);
      f[2] = ($urandom % 8) == 0;
      tag = fv ? "R10" : (fl ? "R5" : "R3");
      step(tag, lv, {16'($urandom % 6), 4'($urandom % 2), 12'($urandom)}, 8'($urandom % 3),
           1'($urandom), 1'($urandom), fv, {16'($urandom % 6), 4'($urandom % 2)},
           8'($urandom % 3), 20'($urandom), f, fl);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule